// File: doc/BRIEF.md
# Six-channel DMA round-robin arbiter

This block sits in front of a shared DMA transfer engine. Each of six channels raises a request line when it has work. The arbiter hands the engine to exactly one channel at a time, using a one-hot grant with a valid flag. A grant lasts until the engine pulses transfer-done. Requests that arrive in the meantime wait, and no active transfer is ever pre-empted.

Priority is a rotating order held as a pointer to the channel that currently ranks highest. Only a completed transfer moves it. When channel N finishes, channel N+1 (modulo six) becomes highest and N becomes lowest. Channels that are still waiting do not affect this. As a result, a lower-numbered request that arrives during a transfer can be served before an older request from a higher-numbered channel. The pointer is visible on an output port.

The control is a two-state machine:
- `ST_IDLE`: no grant is held. If any request is pending, the GRANT transition latches the winner and moves to `ST_BUSY`; otherwise the machine stays in `ST_IDLE`.
- `ST_BUSY`: one channel owns the engine. The HOLD transition keeps it there until transfer-done. The RELEASE transition then advances the pointer and returns to `ST_IDLE`.

A grant appears one clock after the request is sampled in `ST_IDLE`. After a done pulse there is one idle cycle, and then the next winner is picked using the already-rotated order.

Top module: `dma_rr_arbiter`

## Requirements
- R1: After reset, `gnt_o` is 0, `gnt_valid_o` is 0 and `top_ptr_o` is 0, which gives the order 0>1>2>3>4>5.
- R2: In idle with requests pending, the arbiter grants the pending channel that comes first when scanning from `top_ptr_o` upward with wrap. Bit k of `gnt_o` set means channel k is granted. The grant is visible one clock after the edge that sampled the request.
- R3: While a grant is active and no done pulse is seen, `gnt_o` and `gnt_valid_o` stay unchanged. This holds whatever the request lines do, including when the owner drops its own request.
- R4: A done pulse sampled while channel N is granted does two things. The grant and the valid flag drop at that edge, and `top_ptr_o` becomes (N+1) mod 6, so channel 5 wraps to 0.
- R5: The new pointer depends only on the finished channel and not on which channels are requesting. For example, after channel 3 finishes the pointer is 4 even when channel 2 is not requesting.
- R6: With no request pending, `gnt_valid_o` stays 0. A request withdrawn before it is granted has no effect on later grants.
- R7: A done pulse while no grant is active is ignored, and `top_ptr_o` does not change.
- R8: `gnt_o` has at most one bit set, and `gnt_valid_o` is 1 exactly when `gnt_o` is non-zero.
- R9: The grant that follows a done pulse is chosen with the rotated order. So channels 0 and 3 requesting together, plus channel 1 arriving during channel 0's transfer, are served in the order 0, 1, 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_CH | Per-channel transfer request |
| xfer_done_i | input | 1 | One-cycle pulse from the engine when the current transfer ends |
| gnt_o | output | NUM_CH | One-hot grant to the owning channel |
| gnt_valid_o | output | 1 | A grant is active |
| top_ptr_o | output | PTR_W | Channel that currently ranks highest |

## Verification
The bench replays the 0/3/1 sequence. An arbiter that rotated on each grant, or that skipped to the next waiting channel instead of N+1, would serve channel 3 before channel 1 or leave the wrong pointer after channel 3. It drops the owner's request mid-transfer, and raises and withdraws a request during a transfer. A design that pre-empted, released on request drop, or latched stale requests would show a changed grant or an unexpected next winner. It also pulses done while idle, where a careless design would rotate the pointer. Finally it walks the pointer through the 5-to-0 wrap with all six channels requesting, which catches an off-by-one in the modulo step.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } arb_state_e;
endpackage

// File: rtl/rr_pick.sv
// Combinational winner search starting at the highest-priority pointer.
module rr_pick #(
    parameter int NUM_CH = 6,
    parameter int PTR_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req_i,
    input  logic [PTR_W-1:0]  ptr_i,
    output logic              any_o,
    output logic [PTR_W-1:0]  idx_o
);
    int c;

    // Scan from lowest rank to highest so the last hit is the winner.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        c     = 0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            c = int'(ptr_i) + i;
            if (c >= NUM_CH) begin
                c = c - NUM_CH;
            end
            if (req_i[c]) begin
                any_o = 1'b1;
                idx_o = PTR_W'(c);
            end
        end
    end
endmodule

// File: rtl/rr_prio_ptr.sv
// Highest-priority pointer; advances past the finished channel.
module rr_prio_ptr #(
    parameter int NUM_CH = 6,
    parameter int PTR_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance_i,
    input  logic [PTR_W-1:0] owner_i,
    output logic [PTR_W-1:0] ptr_o
);
    localparam logic [PTR_W-1:0] LAST_CH = PTR_W'(NUM_CH - 1);

    logic [PTR_W-1:0] ptr_d;

    always_comb begin
        ptr_d = ptr_o;
        if (advance_i) begin
            ptr_d = (owner_i == LAST_CH) ? '0 : owner_i + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_o <= '0;
        end else begin
            ptr_o <= ptr_d;
        end
    end
endmodule

// File: rtl/rr_ctrl_fsm.sv
// Grant ownership state machine: GRANT, HOLD, RELEASE.
module rr_ctrl_fsm
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int PTR_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_i,
    input  logic [PTR_W-1:0] win_i,
    input  logic             done_i,
    output logic             busy_o,
    output logic [PTR_W-1:0] owner_o,
    output logic             advance_o
);
    arb_state_e       state_q, state_d;
    logic [PTR_W-1:0] owner_q, owner_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        owner_d   = owner_q;
        advance_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_i) begin
                    state_d = ST_BUSY;
                    owner_d = win_i;
                end
            end
            ST_BUSY: begin
                if (done_i) begin
                    state_d   = ST_IDLE;
                    advance_o = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy_o  = (state_q == ST_BUSY);
    assign owner_o = owner_q;
endmodule

// File: rtl/dma_rr_arbiter.sv
module dma_rr_arbiter #(
    parameter int NUM_CH = 6,
    localparam int PTR_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    input  logic              xfer_done_i,
    output logic [NUM_CH-1:0] gnt_o,
    output logic              gnt_valid_o,
    output logic [PTR_W-1:0]  top_ptr_o
);
    logic             any_req;
    logic [PTR_W-1:0] win_idx;
    logic             busy;
    logic [PTR_W-1:0] owner;
    logic             advance;

    rr_pick #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_pick (
        .req_i (req_i),
        .ptr_i (top_ptr_o),
        .any_o (any_req),
        .idx_o (win_idx)
    );

    rr_ctrl_fsm #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_i     (any_req),
        .win_i     (win_idx),
        .done_i    (xfer_done_i),
        .busy_o    (busy),
        .owner_o   (owner),
        .advance_o (advance)
    );

    rr_prio_ptr #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (advance),
        .owner_i   (owner),
        .ptr_o     (top_ptr_o)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_gnt
        assign gnt_o[g] = busy && (owner == PTR_W'(g));
    end

    assign gnt_valid_o = busy;
endmodule

// File: rtl/dma_rr_arbiter_chk.sv
module dma_rr_arbiter_chk #(
    parameter int NUM_CH = 6,
    localparam int PTR_W = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] req_i,
    input logic              xfer_done_i,
    input logic [NUM_CH-1:0] gnt_o,
    input logic              gnt_valid_o,
    input logic [PTR_W-1:0]  top_ptr_o
);
    logic [PTR_W-1:0] after_owner;

    // Pointer expected once the channel shown on gnt_o finishes.
    always_comb begin
        after_owner = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (gnt_o[k]) begin
                after_owner = (k == NUM_CH - 1) ? '0 : PTR_W'(k + 1);
            end
        end
    end

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o) && (gnt_valid_o == (gnt_o != '0)));

    // R2
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_valid_o) |-> (($past(req_i) & gnt_o) != '0));

    // R3
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid_o && !xfer_done_i) |=> (gnt_valid_o && $stable(gnt_o)));

    // R4
    release_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid_o && xfer_done_i) |=> !gnt_valid_o);

    // R4
    ptr_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid_o && xfer_done_i) |=> (top_ptr_o == $past(after_owner)));

    // R7
    ptr_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_valid_o && xfer_done_i) |=> $stable(top_ptr_o));

    // R6
    no_req_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid_o && (req_i == '0)) |=> !gnt_valid_o);
endmodule

bind dma_rr_arbiter dma_rr_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .xfer_done_i (xfer_done_i),
    .gnt_o       (gnt_o),
    .gnt_valid_o (gnt_valid_o),
    .top_ptr_o   (top_ptr_o)
);

// File: tb/test_dma_rr_arbiter.sv
module test_dma_rr_arbiter;
    localparam int NCH = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] req = '0;
    logic           done = 1'b0;
    logic [NCH-1:0] gnt;
    logic           gnt_valid;
    logic [2:0]     top_ptr;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int exp_q[$];
    bit prev_v = 1'b0;

    always #2 clk = ~clk;

    dma_rr_arbiter i_dma_rr_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .xfer_done_i (done),
        .gnt_o       (gnt),
        .gnt_valid_o (gnt_valid),
        .top_ptr_o   (top_ptr)
    );

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int onehot_idx(logic [NCH-1:0] v);
        int r = -1;
        for (int k = 0; k < NCH; k++) if (v[k]) r = k;
        return r;
    endfunction

    // Monitor: each new grant is compared with the next expected channel.
    always @(negedge clk) begin
        if (rst_n) begin
            if (gnt_valid && !prev_v) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected grant", onehot_idx(gnt), -1);
                end else begin
                    check("R2/R9 grant order", onehot_idx(gnt), exp_q.pop_front());
                end
                check("R8 onehot", $countones(gnt), 1);
            end
            prev_v <= gnt_valid;
        end
    end

    // Driver: expect channel exp, optionally raise add_m after the grant and
    // withdraw drop_m later, finish the transfer, check the new pointer.
    task automatic serve(int exp, int nptr, logic [NCH-1:0] add_m, logic [NCH-1:0] drop_m);
        int n = 0;
        exp_q.push_back(exp);
        while (!gnt_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        check("R2 grant arrives", int'(gnt_valid), 1);
        req = req | add_m;
        @(negedge clk);
        check("R3 hold with new request", int'(gnt), int'(1 << exp));
        req = req & ~drop_m & ~NCH'(1 << exp);
        @(negedge clk);
        check("R3 hold after request drop", int'(gnt), int'(1 << exp));
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        check("R4 release", int'(gnt_valid), 0);
        check("R4/R5 pointer", int'(top_ptr), nptr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 gnt", int'(gnt), 0);
        check("R1 valid", int'(gnt_valid), 0);
        check("R1 ptr", int'(top_ptr), 0);

        // R9 worked sequence: 0 and 3 together, 1 arrives during 0.
        req = 6'b001001;
        serve(0, 1, 6'b000010, 6'b000000);
        serve(1, 2, 6'b000000, 6'b000000);
        serve(3, 4, 6'b000000, 6'b000000); // R5: channel 2 idle, pointer 4

        // R6 no requests, no grant
        repeat (5) @(negedge clk);
        check("R6 idle no grant", int'(gnt_valid), 0);
        // R7 done while idle
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        @(negedge clk);
        check("R7 idle done ignored", int'(top_ptr), 4);
        check("R7 still no grant", int'(gnt_valid), 0);

        // R6 withdrawn request: 5 beats 2, 0 raised and dropped in transfer
        req = 6'b100100;
        serve(5, 0, 6'b000001, 6'b000001);
        serve(2, 3, 6'b000000, 6'b000000);

        // R2 order from pointer 3: 4 beats 1
        req = 6'b010010;
        serve(4, 5, 6'b000000, 6'b000000);
        serve(1, 2, 6'b000000, 6'b000000);

        // R4 wrap 5 -> 0
        req = 6'b100000;
        serve(5, 0, 6'b000000, 6'b000000);

        // All channels requesting from pointer 0
        req = 6'b111111;
        for (int c = 0; c < NCH; c++) begin
            serve(c, (c + 1) % NCH, 6'b000000, 6'b000000);
        end
        repeat (3) @(negedge clk);
        check("R6 queue drained", exp_q.size(), 0);
        check("R6 final idle", int'(gnt_valid), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule